// File: doc/BRIEF.md
# Dual-Rail Saturating Output Stage with Sticky Alarms

This block sits after a pair of in-phase (I) and quadrature (Q) filter accumulators. Each cycle in which `valid_i` is high, it takes a wide signed accumulator result for each rail and applies a fixed arithmetic right shift. It then reduces the result to a narrower signed output word. Results that fit pass through unchanged. Results above the output range are clamped to the largest positive code. Results below the symmetric range are clamped to the negated largest code, so the most negative two's-complement code is never produced.

Every clamp is an event that sets a sticky status bit. Each rail has its own overflow bit and its own underflow bit. A summary alarm bit is also latched. It is set by any of the four saturation events or by an external FIFO underflow indication. A clear strobe drops all latched bits, but an event in the same cycle as the clear keeps its bit set. Output words, the output valid and all flags are registered, one cycle after the input.

Top module: `sat_status_top`

## Requirements
- R1: While reset is asserted and after its release with no input, `valid_o`, both output words and all five flags are 0.
- R2: A sample with `valid_i`=1 whose shifted value `acc >>> SHIFT` (arithmetic shift, SHIFT=4) lies in [-32767, 32767] appears unchanged on the 16-bit output one cycle later, with `valid_o`=1 for that cycle. It sets no flag.
- R3: A shifted value above 32767 gives 32767 on the output and sets that rail's overflow flag (`i_ovf_o` or `q_ovf_o`).
- R4: A shifted value below -32767, including exactly -32768, gives -32767 on the output and sets that rail's underflow flag (`i_unf_o` or `q_unf_o`). The output never shows -32768.
- R5: When `valid_i`=0, the output words hold their last values and `valid_o` is 0. Out-of-range accumulator inputs set no flag in such a cycle.
- R6: Every flag stays set in later cycles until a clear is applied.
- R7: `clear_i`=1 with no event in that cycle resets all five flags one cycle later.
- R8: If an event and `clear_i` occur in the same cycle, the event's flag, and the alarm, remain set.
- R9: `alarm_o` is set one cycle after any of the four saturation events or after `fifo_unf_i`=1. `fifo_unf_i` acts regardless of `valid_i` and sets no rail flag.
- R10: The I and Q rails are independent: an event on one rail changes neither the other rail's output nor its flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Accumulator results valid this cycle |
| i_acc_i | input | 24 | I accumulator result, signed |
| q_acc_i | input | 24 | Q accumulator result, signed |
| fifo_unf_i | input | 1 | FIFO underflow event |
| clear_i | input | 1 | Clear strobe for all latched flags |
| valid_o | output | 1 | Output words updated this cycle |
| i_data_o | output | 16 | I output word, signed |
| q_data_o | output | 16 | Q output word, signed |
| i_ovf_o | output | 1 | Sticky I positive saturation |
| i_unf_o | output | 1 | Sticky I negative saturation |
| q_ovf_o | output | 1 | Sticky Q positive saturation |
| q_unf_o | output | 1 | Sticky Q negative saturation |
| alarm_o | output | 1 | Sticky summary of all saturation and FIFO underflow events |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it: the output words, `valid_o`, the four rail flags and the alarm. A clear takes effect at that same single edge. The bench drives a whole cycle's inputs on the falling edge. Its behavioural model steps at the rising edge that samples those inputs, and every output is compared one time unit after that edge. The comparison therefore sees the registered result of exactly that cycle. Because this comparison runs on every cycle, held values, flag persistence and the absence of side effects are checked in the cycles between stimuli as well.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int NUM_RAILS = 2;
  localparam int RAIL_I    = 0;
  localparam int RAIL_Q    = 1;

  typedef struct packed {
    logic ovf;
    logic unf;
  } rail_evt_t;
endpackage

// File: rtl/sat_rail.sv
module sat_rail #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  acc_i,
  output logic signed [OUT_W-1:0] data_o,
  output sat_pkg::rail_evt_t      evt_o
);
  localparam logic signed [IN_W-1:0] MAX_EXT =
    {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MIN_EXT = -MAX_EXT;
  localparam logic signed [OUT_W-1:0] MAX_OUT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MIN_OUT = -MAX_OUT;
  localparam logic signed [OUT_W-1:0] BAD_OUT = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0]  shifted;
  logic                    over, under;
  logic signed [OUT_W-1:0] clamped;

  assign shifted = acc_i >>> SHIFT;
  assign over    = shifted > MAX_EXT;
  // Symmetric range: the most negative code also counts as underflow
  assign under   = shifted < MIN_EXT;

  always_comb begin
    if (over)       clamped = MAX_OUT;
    else if (under) clamped = MIN_OUT;
    else            clamped = shifted[OUT_W-1:0];
  end

  assign evt_o.ovf = valid_i & over;
  assign evt_o.unf = valid_i & under;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (valid_i) data_o <= clamped;
  end

  AST_POS_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ($signed(acc_i >>> SHIFT) > MAX_EXT)) |=> data_o == MAX_OUT); // R3
  AST_NEG_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ($signed(acc_i >>> SHIFT) < MIN_EXT)) |=> data_o == MIN_OUT); // R4
  AST_NO_MIN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o != BAD_OUT); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)); // R5
endmodule

// File: rtl/sticky_bit.sv
module sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  output logic q_o
);
  // Set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (clear_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clear_i) |=> q_o); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !set_i) |=> !q_o); // R7
endmodule

// File: rtl/sat_status_top.sv
module sat_status_top #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  i_acc_i,
  input  logic signed [IN_W-1:0]  q_acc_i,
  input  logic                    fifo_unf_i,
  input  logic                    clear_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] i_data_o,
  output logic signed [OUT_W-1:0] q_data_o,
  output logic                    i_ovf_o,
  output logic                    i_unf_o,
  output logic                    q_ovf_o,
  output logic                    q_unf_o,
  output logic                    alarm_o
);
  import sat_pkg::*;

  logic signed [IN_W-1:0]  acc   [NUM_RAILS];
  logic signed [OUT_W-1:0] dout  [NUM_RAILS];
  rail_evt_t               evt   [NUM_RAILS];
  logic [NUM_RAILS-1:0]    ovf_q, unf_q;
  logic [NUM_RAILS-1:0]    rail_any;
  logic                    alarm_set;

  assign acc[RAIL_I] = i_acc_i;
  assign acc[RAIL_Q] = q_acc_i;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    sat_rail #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_rail (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .acc_i   (acc[r]),
      .data_o  (dout[r]),
      .evt_o   (evt[r])
    );
    sticky_bit u_ovf (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt[r].ovf),
      .clear_i(clear_i), .q_o(ovf_q[r])
    );
    sticky_bit u_unf (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt[r].unf),
      .clear_i(clear_i), .q_o(unf_q[r])
    );
    assign rail_any[r] = evt[r].ovf | evt[r].unf;
  end

  assign alarm_set = (|rail_any) | fifo_unf_i;

  sticky_bit u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(alarm_set),
    .clear_i(clear_i), .q_o(alarm_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign i_data_o = dout[RAIL_I];
  assign q_data_o = dout[RAIL_Q];
  assign i_ovf_o  = ovf_q[RAIL_I];
  assign i_unf_o  = unf_q[RAIL_I];
  assign q_ovf_o  = ovf_q[RAIL_Q];
  assign q_unf_o  = unf_q[RAIL_Q];

  AST_ALARM_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_ovf_o | i_unf_o | q_ovf_o | q_unf_o) |-> alarm_o); // R9
  AST_FIFO_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_unf_i |=> alarm_o); // R9
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_NO_FLAG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !i_ovf_o) |=> !i_ovf_o); // R5
endmodule

// File: tb/tb_sat_status_top.sv
module tb_sat_status_top;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT = 4;

  logic clk = 0, rst_ni = 0;
  logic valid_i = 0, fifo_unf_i = 0, clear_i = 0;
  logic signed [23:0] i_acc_i = '0, q_acc_i = '0;
  logic valid_o, i_ovf_o, i_unf_o, q_ovf_o, q_unf_o, alarm_o;
  logic signed [15:0] i_data_o, q_data_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // model state
  int  m_di = 0, m_dq = 0;
  bit  m_v = 0, m_iovf = 0, m_iunf = 0, m_qovf = 0, m_qunf = 0, m_alarm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_status_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .i_acc_i(i_acc_i), .q_acc_i(q_acc_i), .fifo_unf_i(fifo_unf_i),
    .clear_i(clear_i), .valid_o(valid_o), .i_data_o(i_data_o),
    .q_data_o(q_data_o), .i_ovf_o(i_ovf_o), .i_unf_o(i_unf_o),
    .q_ovf_o(q_ovf_o), .q_unf_o(q_unf_o), .alarm_o(alarm_o)
  );

  function automatic int scaled(input logic signed [23:0] x);
    int v;
    v = x;
    return v >>> SHIFT;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "valid_o", int'(valid_o), int'(m_v));
    chk(tag, "i_data_o", int'(i_data_o), m_di);
    chk(tag, "q_data_o", int'(q_data_o), m_dq);
    chk(tag, "i_ovf_o", int'(i_ovf_o), int'(m_iovf));
    chk(tag, "i_unf_o", int'(i_unf_o), int'(m_iunf));
    chk(tag, "q_ovf_o", int'(q_ovf_o), int'(m_qovf));
    chk(tag, "q_unf_o", int'(q_unf_o), int'(m_qunf));
    chk(tag, "alarm_o", int'(alarm_o), int'(m_alarm));
  endtask

  task automatic step(input string tag, input bit v, input int ia, input int qa,
                      input bit fu, input bit clr);
    int si, sq;
    bit eio, eiu, eqo, equ;
    @(negedge clk);
    valid_i = v; i_acc_i = ia[23:0]; q_acc_i = qa[23:0];
    fifo_unf_i = fu; clear_i = clr;
    @(posedge clk);
    si = scaled(ia[23:0]); sq = scaled(qa[23:0]);
    eio = v && si > 32767;  eiu = v && si < -32767;
    eqo = v && sq > 32767;  equ = v && sq < -32767;
    m_v = v;
    if (v) begin
      m_di = eio ? 32767 : (eiu ? -32767 : si);
      m_dq = eqo ? 32767 : (equ ? -32767 : sq);
    end
    m_iovf  = eio | (m_iovf & !clr);
    m_iunf  = eiu | (m_iunf & !clr);
    m_qovf  = eqo | (m_qovf & !clr);
    m_qunf  = equ | (m_qunf & !clr);
    m_alarm = eio | eiu | eqo | equ | fu | (m_alarm & !clr);
    #1;
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    compare_all("R1");           // in reset
    rst_ni = 1;
    step("R1", 0, 0, 0, 0, 0);
    // R2 in-range values, various patterns
    step("R2", 1, 'h000100, -'h100, 0, 0);
    step("R2", 1, 'h07FFF0, 'hF80010, 0, 0); // +32767 / -32767 edges
    step("R2", 1, 'h07FFFF, -'h1, 0, 0);
    step("R2", 1, 12345, -98765, 0, 0);
    // R5 idle cycles with out-of-range inputs
    step("R5", 0, 'h7FFFFF, 'h800000, 0, 0);
    step("R5", 0, 'h100000, -'h100000, 0, 0);
    // R9 fifo underflow alone, valid low
    step("R9", 0, 0, 0, 1, 0);
    step("R6", 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1);
    // R3 I overflow, Q unaffected (R10)
    step("R3", 1, 'h080000, 'h000200, 0, 0);
    step("R10", 1, 'h000010, 'h000020, 0, 0);
    step("R6", 1, 'h7FFFFF, 'h000030, 0, 0);
    step("R7", 0, 0, 0, 0, 1);
    // R4 Q underflow, exactly -32768 scaled
    step("R4", 1, 'h000040, 'hF80000, 0, 0);
    step("R4", 1, 'h800000, 'h000050, 0, 0);
    step("R6", 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1);
    // R3 Q overflow, R4 I underflow together
    step("R3", 1, -'h200000, 'h200000, 0, 0);
    step("R7", 1, 'h000100, 'h000100, 0, 1);
    // R8 event and clear in the same cycle
    step("R8", 1, 'h100000, 0, 0, 0);
    step("R8", 1, 'h100000, 0, 0, 1);
    step("R8", 0, 0, 0, 1, 1);
    step("R7", 0, 0, 0, 0, 1);
    step("R8", 1, 0, -'h400000, 0, 1);
    step("R6", 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1);
    for (int k = 0; k < 40; k++)
      step("R2", 1, (k * 52711) % 'h200000 - 'h100000, (k * 91393) % 'h180000 - 'hC0000, 0, k % 9 == 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule